// File: doc/BRIEF.md
# Eight-Pin General-Purpose Port with Edge Events

A byte-wide, memory-mapped pin bank. Software reaches it through a simple register bus with a write strobe, an address and a combinational read path. It sets each pin's direction, output level, pull resistor and peripheral function. It also watches every pin for a chosen edge. Each pin's output value comes from the port's own output register, or from a primary or secondary peripheral, depending on the pin's two function-select bits. The output register has a second job: when a pin's resistor is enabled, the same bit chooses pull-up or pull-down.

Pin levels are resynchronised through two flops before the port uses them. A pin whose selected edge arrives latches a sticky event flag. Software can set or clear that flag by writing the flag register. A single request line is raised whenever any flag is set together with its enable bit. The core reset is asserted asynchronously and released synchronously. It clears the direction, flag, enable, function-select and resistor registers. The output and edge-select registers keep their contents through it.

Top module: `edge_gpio_port`

## Requirements
- R1: Registers are at byte addresses 0x21 output, 0x22 direction, 0x23 flags, 0x24 edge select, 0x25 event enable, 0x26 function select A, 0x27 resistor enable and 0x41 function select B. A write of a value is read back unchanged from the same address. Any unmapped address reads as 0.
- R2: Address 0x20 returns the pin levels. A change on the pins is visible there after exactly two rising clock edges. Writes to 0x20 have no effect.
- R3: pad_oe bit n equals direction bit n: 1 means the pin drives and 0 means it is an input.
- R4: pad_out bit n follows the code {select A bit n, select B bit n}: 00 gives the output register, 01 gives prim_out, 11 gives sec_out, and the reserved code 10 behaves as 00.
- R5: pad_pull_en bit n equals resistor-enable bit n, and pad_pull_up bit n equals output-register bit n (1 means pull up, 0 means pull down).
- R6: With edge-select bit 0, a low-to-high pin transition sets flag n. With edge-select bit 1, a high-to-low transition sets it. The flag reads 1 after the third rising clock edge that follows the pin change, and the opposite transition leaves it clear.
- R7: Flags stay set until software writes 0 to them. Writing the flag register loads every bit from the written data, so a written 1 also sets a flag.
- R8: A hardware edge and a software clear of the same flag in the same cycle leave the flag set.
- R9: irq is 1 exactly when some flag and its enable bit are both 1.
- R10: Reset clears the direction, flag, enable, both function-select and resistor-enable registers, and keeps the output and edge-select registers.
- R11: A pin level that differs from the reset value of the synchronizer when reset is released raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pad_in | input | 8 | Pin levels, asynchronous to clk |
| pad_oe | output | 8 | Per-pin drive enable |
| pad_out | output | 8 | Per-pin drive value |
| pad_pull_en | output | 8 | Per-pin resistor enable |
| pad_pull_up | output | 8 | Per-pin resistor direction, 1 means up |
| prim_out | input | 8 | Primary peripheral output values |
| sec_out | input | 8 | Secondary peripheral output values |
| irq | output | 1 | Combined event request |

## Verification
The assertions take the pin inputs to change no more than once per clock and the bus strobe to be clean at each rising edge. They also assume nothing about the edge-select contents before software first writes them. To stay within these assumptions, the stimulus writes edge select before it moves any pin. It changes pins and bus signals only at the falling clock edge. After each pin move it holds the pins steady for several cycles before it clears the flags. Around reset it keeps the pins constant, so that only the synchronizer's own start-up mismatch is present.

// File: rtl/egp_pkg.sv
package egp_pkg;
  localparam int EGP_AW = 8;

  localparam logic [EGP_AW-1:0] OFS_LEVEL = 8'h20;
  localparam logic [EGP_AW-1:0] OFS_DRIVE = 8'h21;
  localparam logic [EGP_AW-1:0] OFS_DIR   = 8'h22;
  localparam logic [EGP_AW-1:0] OFS_FLAG  = 8'h23;
  localparam logic [EGP_AW-1:0] OFS_POL   = 8'h24;
  localparam logic [EGP_AW-1:0] OFS_MASK  = 8'h25;
  localparam logic [EGP_AW-1:0] OFS_FSA   = 8'h26;
  localparam logic [EGP_AW-1:0] OFS_PULL  = 8'h27;
  localparam logic [EGP_AW-1:0] OFS_FSB   = 8'h41;

  typedef enum logic [1:0] {
    FN_GPIO = 2'b00,
    FN_PRIM = 2'b01,
    FN_RSVD = 2'b10,
    FN_SEC  = 2'b11
  } egp_fn_e;
endpackage

// File: rtl/egp_sync.sv
module egp_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg1_q, stg2_q;
  logic [W-1:0] stg1_d, stg2_d;

  always_comb begin
    stg1_d = d;
    stg2_d = stg1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '0;
      stg2_q <= '0;
    end else begin
      stg1_q <= stg1_d;
      stg2_q <= stg2_d;
    end
  end

  assign q = stg2_q;

  // R2
  sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(rst_n)) |-> (q == $past(d, 2)));
endmodule

// File: rtl/egp_edge_flags.sv
module egp_edge_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] fall_sel,
  input  logic         sw_we,
  input  logic [W-1:0] sw_data,
  output logic [W-1:0] flag
);
  localparam int WARM_W = 2;
  localparam logic [WARM_W-1:0] WARM_DONE = '1;

  logic [W-1:0]      prev_q, prev_d;
  logic [W-1:0]      flag_q, flag_d;
  logic [WARM_W-1:0] warm_q, warm_d;
  logic              warm_ok;
  logic [W-1:0]      rise, fall, hw_set;

  assign warm_ok = (warm_q == WARM_DONE);
  assign rise    = lvl & ~prev_q;
  assign fall    = ~lvl & prev_q;
  assign hw_set  = warm_ok ? ((rise & ~fall_sel) | (fall & fall_sel)) : '0;

  always_comb begin
    prev_d = lvl;
    warm_d = warm_ok ? warm_q : warm_q + 1'b1;
    flag_d = flag_q;
    if (sw_we) flag_d = sw_data;
    flag_d = flag_d | hw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      warm_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= prev_d;
      warm_q <= warm_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

  // R6
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag & ~$past(flag) & ~$past(hw_set) & ~($past(sw_we) ? $past(sw_data) : '0)) == '0);
  // R6
  edge_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set & fall_sel & lvl) == '0 && (hw_set & ~fall_sel & ~lvl) == '0);
  // R8
  hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hw_set) & ~flag) == '0);
  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (~flag & $past(flag) & ~{W{$past(sw_we)}}) == '0);
  // R11
  warm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !warm_ok |-> (hw_set == '0));
endmodule

// File: rtl/egp_pin_mux.sv
module egp_pin_mux #(
  parameter int W = 8
) (
  input  logic [W-1:0] fsel_a,
  input  logic [W-1:0] fsel_b,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] drive,
  input  logic [W-1:0] pull,
  input  logic [W-1:0] prim_out,
  input  logic [W-1:0] sec_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_pull_en,
  output logic [W-1:0] pad_pull_up
);
  import egp_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_pin
    egp_fn_e fn;
    assign fn = egp_fn_e'({fsel_a[i], fsel_b[i]});
    always_comb begin
      unique case (fn)
        FN_PRIM: pad_out[i] = prim_out[i];
        FN_SEC:  pad_out[i] = sec_out[i];
        default: pad_out[i] = drive[i];
      endcase
    end
    assign pad_oe[i]      = dir[i];
    assign pad_pull_en[i] = pull[i];
    assign pad_pull_up[i] = drive[i];
  end
endmodule

// File: rtl/edge_gpio_port.sv
module edge_gpio_port #(
  parameter int WIDTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [egp_pkg::EGP_AW-1:0] bus_addr,
  input  logic                       bus_we,
  input  logic [WIDTH-1:0]           bus_wdata,
  output logic [WIDTH-1:0]           bus_rdata,
  input  logic [WIDTH-1:0]           pad_in,
  output logic [WIDTH-1:0]           pad_oe,
  output logic [WIDTH-1:0]           pad_out,
  output logic [WIDTH-1:0]           pad_pull_en,
  output logic [WIDTH-1:0]           pad_pull_up,
  input  logic [WIDTH-1:0]           prim_out,
  input  logic [WIDTH-1:0]           sec_out,
  output logic                       irq
);
  import egp_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic rst_m_q, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q    <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_m_q    <= 1'b1;
      rst_core_n <= rst_m_q;
    end
  end

  logic [WIDTH-1:0] dir_q, dir_d, mask_q, mask_d, fsa_q, fsa_d;
  logic [WIDTH-1:0] fsb_q, fsb_d, pull_q, pull_d;
  logic [WIDTH-1:0] drive_q, drive_d, pol_q, pol_d;
  logic [WIDTH-1:0] lvl_sync, flag;
  logic             we_dir, we_mask, we_fsa, we_fsb, we_pull;
  logic             we_drive, we_pol, we_flag;

  assign we_dir   = bus_we && (bus_addr == OFS_DIR);
  assign we_mask  = bus_we && (bus_addr == OFS_MASK);
  assign we_fsa   = bus_we && (bus_addr == OFS_FSA);
  assign we_fsb   = bus_we && (bus_addr == OFS_FSB);
  assign we_pull  = bus_we && (bus_addr == OFS_PULL);
  assign we_drive = bus_we && (bus_addr == OFS_DRIVE);
  assign we_pol   = bus_we && (bus_addr == OFS_POL);
  assign we_flag  = bus_we && (bus_addr == OFS_FLAG);

  always_comb begin
    dir_d   = we_dir   ? bus_wdata : dir_q;
    mask_d  = we_mask  ? bus_wdata : mask_q;
    fsa_d   = we_fsa   ? bus_wdata : fsa_q;
    fsb_d   = we_fsb   ? bus_wdata : fsb_q;
    pull_d  = we_pull  ? bus_wdata : pull_q;
    drive_d = we_drive ? bus_wdata : drive_q;
    pol_d   = we_pol   ? bus_wdata : pol_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      dir_q  <= '0;
      mask_q <= '0;
      fsa_q  <= '0;
      fsb_q  <= '0;
      pull_q <= '0;
    end else begin
      dir_q  <= dir_d;
      mask_q <= mask_d;
      fsa_q  <= fsa_d;
      fsb_q  <= fsb_d;
      pull_q <= pull_d;
    end
  end

  // output level and edge polarity survive reset
  always_ff @(posedge clk) begin
    drive_q <= drive_d;
    pol_q   <= pol_d;
  end

  egp_sync #(.W(WIDTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     (pad_in),
    .q     (lvl_sync)
  );

  egp_edge_flags #(.W(WIDTH)) u_flags (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .lvl      (lvl_sync),
    .fall_sel (pol_q),
    .sw_we    (we_flag),
    .sw_data  (bus_wdata),
    .flag     (flag)
  );

  egp_pin_mux #(.W(WIDTH)) u_mux (
    .fsel_a      (fsa_q),
    .fsel_b      (fsb_q),
    .dir         (dir_q),
    .drive       (drive_q),
    .pull        (pull_q),
    .prim_out    (prim_out),
    .sec_out     (sec_out),
    .pad_oe      (pad_oe),
    .pad_out     (pad_out),
    .pad_pull_en (pad_pull_en),
    .pad_pull_up (pad_pull_up)
  );

  always_comb begin
    unique case (bus_addr)
      OFS_LEVEL: bus_rdata = lvl_sync;
      OFS_DRIVE: bus_rdata = drive_q;
      OFS_DIR:   bus_rdata = dir_q;
      OFS_FLAG:  bus_rdata = flag;
      OFS_POL:   bus_rdata = pol_q;
      OFS_MASK:  bus_rdata = mask_q;
      OFS_FSA:   bus_rdata = fsa_q;
      OFS_PULL:  bus_rdata = pull_q;
      OFS_FSB:   bus_rdata = fsb_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign irq = |(flag & mask_q);

  // R1
  drive_readback_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    we_drive |=> (drive_q == $past(bus_wdata)));
  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mask_q == '0) |-> !irq);
  // R10
  reset_clear_chk: assert property (@(posedge clk)
    $rose(rst_core_n) |-> (dir_q == '0 && mask_q == '0 && fsa_q == '0 && fsb_q == '0 && pull_q == '0));
endmodule

// File: tb/edge_gpio_port_tb.sv
module edge_gpio_port_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic       bus_we;
  logic [7:0] pad_in, pad_oe, pad_out, pad_pull_en, pad_pull_up;
  logic [7:0] prim_out, sec_out;
  logic       irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_gpio_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pull_en(pad_pull_en),
    .pad_pull_up(pad_pull_up), .prim_out(prim_out), .sec_out(sec_out),
    .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [7:0] mux_exp(input logic [7:0] a, input logic [7:0] b,
                                         input logic [7:0] o, input logic [7:0] p,
                                         input logic [7:0] s);
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      case ({a[i], b[i]})
        2'b01:   r[i] = p[i];
        2'b11:   r[i] = s[i];
        default: r[i] = o[i];
      endcase
    return r;
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic [7:0] addrs [8];
    rst_n = 1'b0; bus_addr = 8'h00; bus_wdata = 8'h00; bus_we = 1'b0;
    pad_in = 8'h00; prim_out = 8'h00; sec_out = 8'h00;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    repeat (6) @(posedge clk);

    // R10 reset state of cleared registers
    rd(8'h22, d); chk("R10 dir after reset", d, 8'h00);
    rd(8'h23, d); chk("R10 flags after reset", d, 8'h00);
    rd(8'h25, d); chk("R10 enable after reset", d, 8'h00);
    rd(8'h26, d); chk("R10 select A after reset", d, 8'h00);
    rd(8'h41, d); chk("R10 select B after reset", d, 8'h00);
    rd(8'h27, d); chk("R10 resistor after reset", d, 8'h00);

    // R1 readback sweep over all registers and several data patterns
    addrs = '{8'h21, 8'h22, 8'h23, 8'h24, 8'h25, 8'h26, 8'h27, 8'h41};
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 8; k++) begin
        logic [7:0] v;
        v = 8'(8'h5A ^ (p * 8'h33) ^ (k * 8'h11));
        wr(addrs[k], v);
        rd(addrs[k], d);
        chk("R1 readback", d, v);
      end
    end
    rd(8'h30, d); chk("R1 unmapped reads zero", d, 8'h00);
    wr(8'h23, 8'h00); wr(8'h25, 8'h00);

    // R2 latency and ignored writes
    bus_addr = 8'h20;
    @(negedge clk); pad_in = 8'hA6;
    @(posedge clk); @(negedge clk); #1 chk("R2 level before 2nd edge", bus_rdata, 8'h00);
    @(posedge clk); @(negedge clk); #1 chk("R2 level after 2 edges", bus_rdata, 8'hA6);
    wr(8'h20, 8'h5F);
    rd(8'h20, d); chk("R2 write to level ignored", d, 8'hA6);
    @(negedge clk); pad_in = 8'h00;
    repeat (5) @(posedge clk);

    // R3 R4 R5 mux sweep
    for (int c = 0; c < 12; c++) begin
      logic [7:0] sa, sb, dv, dr, pu;
      sa = 8'(c * 8'h1D ^ 8'h5A); sb = 8'(c * 8'h2B ^ 8'h33);
      dv = 8'(c * 8'h47 ^ 8'h0F); dr = 8'(c * 8'h13 ^ 8'hC3);
      pu = 8'(c * 8'h61 ^ 8'h96);
      prim_out = 8'(c * 8'h35 ^ 8'hF0); sec_out = 8'(c * 8'h6B ^ 8'h0F);
      wr(8'h26, sa); wr(8'h41, sb); wr(8'h21, dv); wr(8'h22, dr); wr(8'h27, pu);
      @(negedge clk); #1;
      chk("R3 pad_oe", pad_oe, dr);
      chk("R4 pad_out", pad_out, mux_exp(sa, sb, dv, prim_out, sec_out));
      chk("R5 pull enable", pad_pull_en, pu);
      chk("R5 pull direction", pad_pull_up, dv);
    end
    wr(8'h26, 8'h00); wr(8'h41, 8'h00); wr(8'h22, 8'h00); wr(8'h27, 8'h00);

    // R6 R9 edge sweep: every bit, both polarities
    for (int b = 0; b < 8; b++) begin
      for (int pol = 0; pol < 2; pol++) begin
        logic [7:0] bm;
        bm = 8'(1 << b);
        wr(8'h24, pol ? bm : 8'h00);
        @(negedge clk); pad_in = pol ? 8'h00 : bm;     // away from start level
        repeat (5) @(posedge clk);
        wr(8'h23, 8'h00);
        @(negedge clk); pad_in = pol ? bm : 8'h00;     // wrong-direction edge
        repeat (5) @(posedge clk);
        rd(8'h23, d); chk("R6 opposite edge leaves flag clear", d, 8'h00);
        bus_addr = 8'h23;
        @(negedge clk); pad_in = pol ? 8'h00 : bm;     // selected edge
        @(posedge clk); @(posedge clk); #1 chk("R6 flag not yet set", bus_rdata, 8'h00);
        @(posedge clk); #1 chk("R6 flag set on selected edge", bus_rdata, bm);
        wr(8'h25, bm);  @(negedge clk); #1 chk("R9 irq enabled flag", {7'd0, irq}, 8'h01);
        wr(8'h25, ~bm); @(negedge clk); #1 chk("R9 irq other enables", {7'd0, irq}, 8'h00);
        wr(8'h25, 8'h00);
        repeat (4) @(posedge clk);
        rd(8'h23, d); chk("R7 flag sticky", d, bm);
      end
    end

    // R7 software set and clear
    @(negedge clk); pad_in = 8'h00;
    repeat (5) @(posedge clk);
    wr(8'h24, 8'h00);
    wr(8'h23, 8'h81); rd(8'h23, d); chk("R7 software set", d, 8'h81);
    wr(8'h25, 8'h80); @(negedge clk); #1 chk("R9 irq from software flag", {7'd0, irq}, 8'h01);
    wr(8'h23, 8'h80); rd(8'h23, d); chk("R7 software partial clear", d, 8'h80);
    wr(8'h25, 8'h00);

    // R8 hardware edge against software clear in the same cycle
    bus_addr = 8'h23;
    @(negedge clk); pad_in = 8'h01;
    @(posedge clk); @(posedge clk);
    @(negedge clk); bus_wdata = 8'h00; bus_we = 1'b1;
    @(posedge clk); #1 bus_we = 1'b0;
    @(negedge clk); #1 chk("R8 hardware edge wins", bus_rdata, 8'h01);

    // R10 R11 retention and quiet start-up
    wr(8'h21, 8'hA5); wr(8'h24, 8'h00); wr(8'h22, 8'hFF); wr(8'h25, 8'hFF);
    @(negedge clk); pad_in = 8'hFF;
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (10) @(posedge clk);
    rd(8'h21, d); chk("R10 output register kept", d, 8'hA5);
    rd(8'h24, d); chk("R10 edge select kept", d, 8'h00);
    rd(8'h22, d); chk("R10 dir cleared", d, 8'h00);
    rd(8'h23, d); chk("R11 no flag from start-up", d, 8'h00);
    rd(8'h20, d); chk("R11 level seen after reset", d, 8'hFF);

    finish_run();
  end
endmodule